// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 sixteen-bit words. The host presents one word access at a time over a valid/ready request channel. The access is a read or a write, with a two-bit byte enable. The controller answers every request with a single-cycle response pulse, and for reads the response carries the data it captured.

On the memory side the controller drives the 18-bit address and the two chip selects, which have opposite polarities. It also drives the active-low write enable, the active-low output enable and the two active-low byte strobes. The shared data bus appears as a separate output value, an output-enable control and an input value. These are meant to meet at a bidirectional pad.

Every phase of a memory cycle lasts a whole number of system clocks. That number comes from a nanosecond minimum, divided by the clock period and rounded up, with a floor of one clock. With the default 10 ns clock, a read lasts 7 clocks. A write lasts 1 setup clock, 5 pulse clocks and 1 recovery clock. A write that follows a read first waits 3 idle turnaround clocks.

Top module: `sram_async_ctrl`

## Requirements
- R1: While and after reset, before any request: cs1_n is 1, cs2 is 0, we_n, oe_n, lb_n and ub_n are 1, the data driver is off, rsp_valid is 0, rsp_rdata is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 for every clock of a memory cycle and its turnaround. rsp_valid is never 1 while req_ready is 0.
- R3: An accepted read with a nonzero byte enable produces a read phase of RD_CYC = ceil(T_RC / CLK_PERIOD_NS) clocks (7 by default). In that phase the chip is selected (cs1_n 0, cs2 1), we_n is 1, oe_n is 0 and sram_addr equals req_addr. The data driver is off whenever oe_n is 0.
- R4: Read data is sampled from sram_dq_i on the clock edge that ends the read phase, while oe_n is still 0. rsp_valid is 1 for the single clock after that edge, which is RD_CYC clocks after the accepting edge, with the sampled word on rsp_rdata.
- R5: During a memory cycle, lb_n is 0 exactly when req_be[0] was 1 and ub_n is 0 exactly when req_be[1] was 1. req_be[0] selects data bits 7:0 and req_be[1] selects bits 15:8.
- R6: A write consists of one setup clock (chip selected, we_n 1, driver on), then WP_CYC = max(ceil(T_WP/CLK), ceil(T_DW/CLK)) clocks with we_n 0, then REC_CYC = max(1, RD_CYC - 1 - WP_CYC) recovery clocks with we_n 1. rsp_valid follows in the next clock, so a write without turnaround responds 1 + WP_CYC + REC_CYC clocks after acceptance (7 by default).
- R7: Throughout a write's setup, pulse and recovery clocks, sram_dq_o equals req_wdata and sram_addr equals req_addr. As a result, the memory stores the enabled bytes of req_wdata and leaves the other byte unchanged.
- R8: A write with a nonzero byte enable, issued after a read and with no nonzero-enable write in between, waits HZ_CYC = ceil(T_HZ/CLK) clocks (3 by default) with the chip deselected and the driver off before its setup clock. Its response is delayed by the same amount.
- R9: A request with req_be equal to 0 causes no memory cycle. rsp_valid rises in the clock after acceptance, and the chip stays deselected. It does not clear a pending read-to-write turnaround.
- R10: cs2 is always the inverse of cs1_n. While the chip is deselected, we_n, oe_n, lb_n and ub_n are all 1, and we_n and oe_n are never 0 together.
- R11: rsp_rdata changes only when a read response is issued. It keeps its value through writes, requests with zero byte enable, and idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Data of the most recent read |
| sram_addr | output | 18 | Memory address |
| sram_dq_o | output | 16 | Data value to drive onto the shared bus |
| sram_dq_oe | output | 1 | Drive enable for the shared bus |
| sram_dq_i | input | 16 | Value seen on the shared bus |
| sram_cs1_n | output | 1 | Chip select, active low |
| sram_cs2 | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |

## Verification
Each response and pin change has a fixed latency from the accepting edge. A read responds RD_CYC clocks later, a write 1 + WP_CYC + REC_CYC clocks later plus HZ_CYC when it follows a read, and a zero-enable request one clock later. When the bench issues a request, it appends one expected pin and response state per upcoming clock to a queue, and it pops and compares one entry at every falling edge, halfway between the register updates. The memory model in the bench returns valid data only after output enable has been low for four clocks, and it puts a marker pattern on the bus otherwise. A controller that samples read data too early, or that writes with the wrong strobes, is therefore exposed through the data it later reads back.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 18,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC          = 70,
  parameter int T_WP          = 50,
  parameter int T_DW          = 30,
  parameter int T_HZ          = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_i,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n
);

  function automatic int clocks(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = clocks(T_RC);
  localparam int WP_CYC  = imax(clocks(T_WP), clocks(T_DW));
  localparam int REC_CYC = imax(1, RD_CYC - 1 - WP_CYC);
  localparam int HZ_CYC  = clocks(T_HZ);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_SETUP, S_PULSE, S_REC
  } state_t;

  state_t           state, nstate;
  logic [CNT_W-1:0] cnt, ncnt;
  logic [1:0]       be_q, nbe;
  logic             after_rd, accept, done, on, drive;

  function automatic logic [CNT_W-1:0] span(input int n);
    return CNT_W'(n - 1);
  endfunction

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign nbe       = accept ? req_be : be_q;
  assign on        = nstate inside {S_READ, S_SETUP, S_PULSE, S_REC};
  assign drive     = nstate inside {S_SETUP, S_PULSE, S_REC};

  always_comb begin
    nstate = state;
    ncnt   = (cnt != '0) ? cnt - 1'b1 : cnt;
    done   = 1'b0;
    case (state)
      S_IDLE:
        if (accept && (|req_be)) begin
          if (!req_we) begin
            nstate = S_READ;
            ncnt   = span(RD_CYC);
          end else if (after_rd) begin
            nstate = S_TURN;
            ncnt   = span(HZ_CYC);
          end else begin
            nstate = S_SETUP;
            ncnt   = '0;
          end
        end else if (accept) begin
          done = 1'b1;
        end
      S_READ:
        if (cnt == '0) begin
          nstate = S_IDLE;
          done   = 1'b1;
        end
      S_TURN:
        if (cnt == '0) nstate = S_SETUP;
      S_SETUP: begin
        nstate = S_PULSE;
        ncnt   = span(WP_CYC);
      end
      S_PULSE:
        if (cnt == '0) begin
          nstate = S_REC;
          ncnt   = span(REC_CYC);
        end
      S_REC:
        if (cnt == '0) begin
          nstate = S_IDLE;
          done   = 1'b1;
        end
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      be_q       <= '0;
      after_rd   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      sram_cs1_n <= 1'b1;
      sram_cs2   <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_lb_n  <= 1'b1;
      sram_ub_n  <= 1'b1;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      rsp_valid <= done;
      if (accept) begin
        be_q      <= req_be;
        sram_addr <= req_addr;
        sram_dq_o <= req_wdata;
      end
      if (state == S_READ && cnt == '0) begin
        rsp_rdata <= sram_dq_i;
        after_rd  <= 1'b1;
      end else if (nstate == S_TURN) begin
        after_rd  <= 1'b0;
      end else if (state == S_IDLE && nstate == S_SETUP) begin
        after_rd  <= 1'b0;
      end
      sram_cs1_n <= !on;
      sram_cs2   <= on;
      sram_we_n  <= (nstate != S_PULSE);
      sram_oe_n  <= (nstate != S_READ);
      sram_dq_oe <= drive;
      sram_lb_n  <= !(on && nbe[0]);
      sram_ub_n  <= !(on && nbe[1]);
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 5,
  parameter int HZ_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic sram_dq_oe,
  input logic sram_cs1_n,
  input logic sram_cs2,
  input logic sram_we_n,
  input logic sram_oe_n,
  input logic sram_lb_n,
  input logic sram_ub_n
);

  int we_run, oe_run, since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run   <= 0;
      oe_run   <= 0;
      since_rd <= HZ_CYC;
    end else begin
      we_run   <= sram_we_n ? 0 : ((we_run < 1000) ? we_run + 1 : we_run);
      oe_run   <= sram_oe_n ? 0 : ((oe_run < 1000) ? oe_run + 1 : oe_run);
      since_rd <= !sram_oe_n ? 0 : ((since_rd < 1000) ? since_rd + 1 : since_rd);
    end
  end

  // R10
  cs_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs1_n == !sram_cs2);

  // R10
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs1_n |-> (sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n));

  // R10
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  // R3
  oe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  // R6
  write_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs1_n && sram_dq_oe && (!sram_lb_n || !sram_ub_n)));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_run >= WP_CYC));

  // R3
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_run >= RD_CYC));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_rd >= HZ_CYC));

  // R2
  rsp_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_dq_oe(sram_dq_oe), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n),
  .sram_ub_n(sram_ub_n)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int CK     = 10;
  localparam int RD_N   = (70 + CK - 1) / CK;
  localparam int WP_A   = (50 + CK - 1) / CK;
  localparam int WP_B   = (30 + CK - 1) / CK;
  localparam int WP_N   = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int REC_N  = (RD_N - 1 - WP_N < 1) ? 1 : RD_N - 1 - WP_N;
  localparam int HZ_N   = (25 + CK - 1) / CK;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, sram_dq_oe;
  logic [15:0] rsp_rdata, sram_dq_o;
  logic [15:0] sram_dq_i = 16'hBAD0;
  logic [17:0] sram_addr;
  logic        sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i),
    .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n)
  );

  typedef struct packed {
    logic        cs, we_n, oe_n, lb_n, ub_n, drv;
    logic [15:0] wd;
    logic [17:0] addr;
    logic        rsp, rd_rsp;
    logic [15:0] rdata;
    logic        ready;
    logic [3:0]  tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] ref_mem [int];
  logic [15:0] sram_mem [int];
  logic [15:0] held = '0;
  bit          run = 0, last_rd = 0;
  int          compared = 0, mismatched = 0, olow = 0, cyc = 0;

  function automatic string rname(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input int tag, input string what, input logic [31:0] a, input logic [31:0] x);
    compared++;
    if (a !== x) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rname(tag), what, a, x, $time);
    end
  endtask

  function automatic exp_t quiet(input int tag, input logic rsp, input logic rd_rsp,
                                 input logic [15:0] rdata, input logic ready);
    exp_t e;
    e = '0;
    e.we_n = 1; e.oe_n = 1; e.lb_n = 1; e.ub_n = 1;
    e.rsp = rsp; e.rd_rsp = rd_rsp; e.rdata = rdata; e.ready = ready;
    e.tag = 4'(tag);
    return e;
  endfunction

  function automatic exp_t active(input int tag, input logic we_n, input logic oe_n,
                                  input logic [1:0] be, input logic drv,
                                  input logic [15:0] wd, input logic [17:0] a);
    exp_t e;
    e = '0;
    e.cs = 1; e.we_n = we_n; e.oe_n = oe_n; e.lb_n = !be[0]; e.ub_n = !be[1];
    e.drv = drv; e.wd = wd; e.addr = a; e.tag = 4'(tag);
    return e;
  endfunction

  function automatic logic [15:0] peek(ref logic [15:0] m [int], input int k);
    return m.exists(k) ? m[k] : 16'h0000;
  endfunction

  // Per-clock comparison against the expected schedule, halfway between edges
  always @(negedge clk) begin
    exp_t e;
    if (run) begin
      e = (q.size() > 0) ? q.pop_front() : quiet(2, 0, 0, 16'h0, 1);
      if (e.rd_rsp) held = e.rdata;
      chk(e.tag, "cs1_n", 32'(sram_cs1_n), 32'(!e.cs));
      chk(10, "cs2 polarity", 32'(sram_cs2), 32'(e.cs));          // R10
      chk(e.tag, "we_n", 32'(sram_we_n), 32'(e.we_n));
      chk(e.tag, "oe_n", 32'(sram_oe_n), 32'(e.oe_n));
      chk(5, "lb_n", 32'(sram_lb_n), 32'(e.lb_n));                // R5
      chk(5, "ub_n", 32'(sram_ub_n), 32'(e.ub_n));                // R5
      chk(e.tag, "dq_oe", 32'(sram_dq_oe), 32'(e.drv));
      if (e.drv) chk(7, "dq_o", 32'(sram_dq_o), 32'(e.wd));       // R7
      if (e.cs) chk(e.tag, "addr", 32'(sram_addr), 32'(e.addr));
      chk(e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
      chk((e.rsp && e.rd_rsp) ? 4 : 11, "rsp_rdata", 32'(rsp_rdata), 32'(held)); // R4 / R11
      chk(2, "req_ready", 32'(req_ready), 32'(e.ready));          // R2
    end
  end

  // Memory model: data valid only after output enable is low for four clocks
  always @(negedge clk) begin
    logic [15:0] w, v;
    if (!sram_oe_n) olow++; else olow = 0;
    if (!sram_cs1_n && sram_cs2 && !sram_we_n) begin
      w = peek(sram_mem, int'(sram_addr));
      if (!sram_lb_n) w[7:0]  = sram_dq_oe ? sram_dq_o[7:0]  : 8'hEE;
      if (!sram_ub_n) w[15:8] = sram_dq_oe ? sram_dq_o[15:8] : 8'hEE;
      sram_mem[int'(sram_addr)] = w;
    end
    if (!sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n && olow >= 4) begin
      v = peek(sram_mem, int'(sram_addr));
      sram_dq_i = {sram_ub_n ? 8'h00 : v[15:8], sram_lb_n ? 8'h00 : v[7:0]};
    end else begin
      sram_dq_i = 16'hBAD0;
    end
  end

  task automatic issue(input logic we, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    int busy;
    logic [15:0] m;
    @(negedge clk); #1;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    busy = 0;
    m = peek(ref_mem, int'(a));
    if (be == 2'b00) begin
      q.push_back(quiet(9, 1, 0, 16'h0, 1));                          // R9
    end else if (!we) begin
      for (int i = 0; i < RD_N; i++) q.push_back(active(3, 1, 0, be, 0, 16'h0, a)); // R3
      q.push_back(quiet(4, 1, 1, {be[1] ? m[15:8] : 8'h00, be[0] ? m[7:0] : 8'h00}, 1)); // R4
      busy = RD_N;
      last_rd = 1;
    end else begin
      if (last_rd) begin
        for (int i = 0; i < HZ_N; i++) q.push_back(quiet(8, 0, 0, 16'h0, 0)); // R8
        busy += HZ_N;
      end
      last_rd = 0;
      q.push_back(active(6, 1, 1, be, 1, d, a));                       // R6 setup
      for (int i = 0; i < WP_N; i++) q.push_back(active(6, 0, 1, be, 1, d, a));
      for (int i = 0; i < REC_N; i++) q.push_back(active(6, 1, 1, be, 1, d, a));
      q.push_back(quiet(6, 1, 0, 16'h0, 1));
      busy += 1 + WP_N + REC_N;
      if (be[0]) m[7:0]  = d[7:0];
      if (be[1]) m[15:8] = d[15:8];
      ref_mem[int'(a)] = m;
    end
    @(posedge clk); #1;
    req_valid = 0;
    repeat (busy) @(posedge clk);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  initial begin
    int unsigned x;
    logic [17:0] a;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(1, "cs1_n", 32'(sram_cs1_n), 1);
    chk(1, "cs2", 32'(sram_cs2), 0);
    chk(1, "we_n", 32'(sram_we_n), 1);
    chk(1, "oe_n", 32'(sram_oe_n), 1);
    chk(1, "lb_n", 32'(sram_lb_n), 1);
    chk(1, "ub_n", 32'(sram_ub_n), 1);
    chk(1, "dq_oe", 32'(sram_dq_oe), 0);
    chk(1, "rsp_valid", 32'(rsp_valid), 0);
    chk(1, "rsp_rdata", 32'(rsp_rdata), 0);
    chk(1, "req_ready", 32'(req_ready), 1);
    #1 rst_n = 1;
    @(negedge clk);
    run = 1;

    issue(1, 18'd5, 16'h1234, 2'b11);          // R6 plain write
    issue(0, 18'd5, 16'h0000, 2'b11);          // R3 R4 full read
    issue(1, 18'd5, 16'hAAFF, 2'b01);          // R8 turnaround, low byte
    issue(1, 18'd5, 16'h56EE, 2'b10);          // R7 high byte only
    issue(0, 18'd5, 16'h0000, 2'b01);          // R5 low byte read
    issue(0, 18'd5, 16'h0000, 2'b10);          // R5 high byte read
    issue(0, 18'd5, 16'h0000, 2'b11);
    issue(1, 18'd5, 16'h0000, 2'b00);          // R9 zero-enable write
    issue(1, 18'd5, 16'h1111, 2'b11);          // R8 still pending after R9
    issue(0, 18'd5, 16'h0000, 2'b00);          // R9 zero-enable read, R11 hold
    issue(0, 18'd5, 16'h0000, 2'b11);
    issue(1, 18'h3FFFF, 16'hCAFE, 2'b11);      // top address
    issue(1, 18'h00000, 16'hBEEF, 2'b11);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b11);
    repeat (4) @(negedge clk);                 // R11 idle hold

    x = 32'h1ACE5EED;
    for (int n = 0; n < 80; n++) begin
      x = x * 1103515245 + 12345;
      a = (x[20]) ? 18'h3FFFF : 18'(x[18:16]);
      issue(x[24], a, x[15:0] ^ x[31:16], x[27:26]);
      if (x[29]) repeat (x[31:30]) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    if (q.size() != 0) chk(2, "schedule drained", 32'(q.size()), 0);
    finish_up();
  end
endmodule